// File: doc/BRIEF.md
# Machine Trap Entry Controller

This block decides, cycle by cycle, whether the core enters a machine-level trap and keeps the registers that describe that trap. It watches two interrupt lines (a timer line and a line from an external interrupt controller), a synchronous exception request with its cause code and the PC of the instruction at commit, and a return-from-trap strobe. When a trap or a return is chosen, it raises a redirect in the same cycle, together with the target PC. It then updates the trap state on the next clock edge.

The state kept here is the global interrupt enable with its saved copy, the saved privilege, the per-source enables, the trap vector (base and mode), the saved exception PC and the cause. It also holds the current privilege, which is machine or user. Software reaches these registers through a simple CSR access port with a combinational read. When an external interrupt is taken, the block pulses an acknowledge to the interrupt controller, which then drops its request.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset the privilege is machine, and reads return: status (0x300) = 0x00000008 (global enable at bit 3 set, saved enable at bit 7 clear, saved privilege at bits 12:11 = 00), enables (0x304) = 0, vector (0x305) = 0, saved PC (0x341) = 0, cause (0x342) = 0.
- R2: An interrupt source is taken only when its line and its enable bit (timer bit 7, external bit 11 of 0x304) are both set, and either the core is in user mode or the global enable is set. Otherwise there is no redirect and the privilege is unchanged.
- R3: When both sources qualify, the timer wins. A taken interrupt records cause bit 31 = 1 with code 7 for the timer or code 11 for external.
- R4: An exception request wins over any interrupt and over a return strobe in the same cycle. It redirects to the vector base whatever the mode, and records cause bit 31 = 0 with the given code (for example 2 illegal, 8 call from user).
- R5: The vector register keeps bits 31:2 as base and bit 0 as mode, and bit 1 always reads 0. With mode 1 an interrupt redirects to base + 4 × code, and with mode 0 it redirects to base.
- R6: On any trap entry the saved PC takes the commit PC, with bits 1:0 reading 0. The saved enable takes the global enable, the global enable clears, the saved privilege takes the current privilege (11 machine, 00 user), and the privilege becomes machine.
- R7: A return strobe redirects to the saved PC. The global enable takes the saved enable, the saved enable becomes 1, the privilege becomes the saved privilege, and the saved privilege becomes 00.
- R8: The acknowledge output is high exactly in the cycle in which an external interrupt is taken, and never when the timer or an exception wins.
- R9: Any access to these six registers from user mode flags illegal. It reads 0 and writes nothing.
- R10: The pending register (0x344) shows the live timer line at bit 7 and the external line at bit 11, and ignores writes. Writes to status ignore bit 7, and store the saved privilege only for 00 or 11; 01 and 10 keep the old value.
- R11: A CSR write in a cycle with a trap entry or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_tmr_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt controller request |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Exception cause code |
| cur_pc_i | input | 32 | PC of the instruction at commit |
| mret_i | input | 1 | Return-from-trap strobe |
| csr_req_i | input | 1 | CSR access valid |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| csr_illegal_o | output | 1 | Access refused for privilege |
| redirect_o | output | 1 | Redirect the fetch this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| ext_ack_o | output | 1 | Acknowledge to the interrupt controller |
| priv_m_o | output | 1 | Current privilege is machine |

## Verification
The bench sweeps all 128 combinations of privilege, global enable, both per-source enables, both lines and vector mode. This separates masking by the global enable from masking by the source enables, checks the timer-over-external order, and compares vectored targets with direct ones. Directed sequences then put an exception, a return and both interrupts in the same cycle to test the arbitration order. They also run a full entry and return through each privilege, and try the write rules for the read-only and restricted-value fields, user-mode accesses, and writes that collide with a trap.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;
    localparam int CODE_W = 4;

    typedef enum logic {PRV_U = 1'b0, PRV_M = 1'b1} prv_e;
    typedef enum logic [1:0] {EV_NONE = 2'd0, EV_EXC = 2'd1, EV_INT = 2'd2, EV_RET = 2'd3} ev_e;

    typedef struct packed {
        ev_e               kind;
        logic              intr;
        logic [CODE_W-1:0] code;
    } trap_dec_t;

    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_IEN    = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_PEND   = 12'h344;

    localparam int B_GIE = 3;
    localparam int B_PIE = 7;
    localparam int B_PPL = 11;
    localparam int B_PPH = 12;
    localparam int B_TMR = 7;
    localparam int B_EXT = 11;

    localparam logic [CODE_W-1:0] C_TMR = 4'd7;
    localparam logic [CODE_W-1:0] C_EXT = 4'd11;

    function automatic logic irq_armed(prv_e p, logic gie);
        return (p == PRV_U) || gie;
    endfunction
endpackage

// File: rtl/mtrap_arb.sv
`timescale 1ns/1ps
module mtrap_arb
    import mtrap_pkg::*;
(
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              mret,
    input  logic              line_tmr,
    input  logic              line_ext,
    input  logic              en_tmr,
    input  logic              en_ext,
    input  logic              gie,
    input  prv_e              prv,
    output trap_dec_t         dec,
    output logic              ext_ack
);
    logic armed, hot_tmr, hot_ext;

    always_comb begin
        armed   = irq_armed(prv, gie);
        hot_tmr = line_tmr & en_tmr;
        hot_ext = line_ext & en_ext;
        dec     = '{kind: EV_NONE, intr: 1'b0, code: '0};
        if (exc_req)
            dec = '{kind: EV_EXC, intr: 1'b0, code: exc_code};
        else if (mret)
            dec.kind = EV_RET;
        else if (armed && hot_tmr)
            dec = '{kind: EV_INT, intr: 1'b1, code: C_TMR};
        else if (armed && hot_ext)
            dec = '{kind: EV_INT, intr: 1'b1, code: C_EXT};
    end

    assign ext_ack = (dec.kind == EV_INT) && (dec.code == C_EXT);
endmodule

// File: rtl/mtrap_vec.sv
`timescale 1ns/1ps
module mtrap_vec
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trap_dec_t       dec,
    input  logic [XLEN-3:0] tv_base,
    input  logic            tv_vec,
    input  logic [XLEN-3:0] epc,
    output logic            redir,
    output logic [XLEN-1:0] redir_pc
);
    localparam int OFS_W = CODE_W + 2;

    logic [XLEN-1:0] base_a, ofs;

    always_comb begin
        base_a = {tv_base, 2'b00};
        ofs    = '0;
        if (dec.kind == EV_INT && tv_vec)
            ofs[OFS_W-1:0] = {dec.code, 2'b00};
        redir = (dec.kind != EV_NONE);
        case (dec.kind)
            EV_RET:  redir_pc = {epc, 2'b00};
            EV_NONE: redir_pc = '0;
            default: redir_pc = base_a + ofs;
        endcase
    end
endmodule

// File: rtl/mtrap_regs.sv
`timescale 1ns/1ps
module mtrap_regs
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  trap_dec_t       dec,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            line_tmr,
    input  logic            line_ext,
    input  logic            csr_req,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output prv_e            prv,
    output logic            gie,
    output logic            en_tmr,
    output logic            en_ext,
    output logic [XLEN-3:0] tv_base,
    output logic            tv_vec,
    output logic [XLEN-3:0] epc
);
    prv_e              pp_q;
    logic              pie_q;
    logic              cint_q;
    logic [CODE_W-1:0] ccode_q;
    logic              hit, wr;
    logic [XLEN-1:0]   rv;

    always_comb begin
        hit = csr_addr inside {A_STATUS, A_IEN, A_TVEC, A_EPC, A_CAUSE, A_PEND};
        csr_illegal = csr_req && hit && (prv == PRV_U);
        wr = csr_req && csr_we && hit && !csr_illegal && (dec.kind == EV_NONE);
        rv = '0;
        case (csr_addr)
            A_STATUS: begin
                rv[B_GIE]         = gie;
                rv[B_PIE]         = pie_q;
                rv[B_PPH:B_PPL]   = {2{pp_q == PRV_M}};
            end
            A_IEN: begin
                rv[B_TMR] = en_tmr;
                rv[B_EXT] = en_ext;
            end
            A_TVEC:  rv = {tv_base, 1'b0, tv_vec};
            A_EPC:   rv = {epc, 2'b00};
            A_CAUSE: begin
                rv[XLEN-1]     = cint_q;
                rv[CODE_W-1:0] = ccode_q;
            end
            A_PEND: begin
                rv[B_TMR] = line_tmr;
                rv[B_EXT] = line_ext;
            end
            default: rv = '0;
        endcase
        csr_rdata = (csr_req && !csr_illegal) ? rv : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prv     <= PRV_M;
            gie     <= 1'b1;
            pie_q   <= 1'b0;
            pp_q    <= PRV_U;
            en_tmr  <= 1'b0;
            en_ext  <= 1'b0;
            tv_base <= '0;
            tv_vec  <= 1'b0;
            epc     <= '0;
            cint_q  <= 1'b0;
            ccode_q <= '0;
        end else begin
            case (dec.kind)
                EV_EXC, EV_INT: begin
                    epc     <= trap_pc[XLEN-1:2];
                    cint_q  <= dec.intr;
                    ccode_q <= dec.code;
                    pie_q   <= gie;
                    gie     <= 1'b0;
                    pp_q    <= prv;
                    prv     <= PRV_M;
                end
                EV_RET: begin
                    gie   <= pie_q;
                    pie_q <= 1'b1;
                    prv   <= pp_q;
                    pp_q  <= PRV_U;
                end
                default: begin
                    if (wr) begin
                        case (csr_addr)
                            A_STATUS: begin
                                gie <= csr_wdata[B_GIE];
                                if (csr_wdata[B_PPH:B_PPL] == 2'b11)
                                    pp_q <= PRV_M;
                                else if (csr_wdata[B_PPH:B_PPL] == 2'b00)
                                    pp_q <= PRV_U;
                            end
                            A_IEN: begin
                                en_tmr <= csr_wdata[B_TMR];
                                en_ext <= csr_wdata[B_EXT];
                            end
                            A_TVEC: begin
                                tv_base <= csr_wdata[XLEN-1:2];
                                tv_vec  <= csr_wdata[0];
                            end
                            A_EPC: epc <= csr_wdata[XLEN-1:2];
                            A_CAUSE: begin
                                cint_q  <= csr_wdata[XLEN-1];
                                ccode_q <= csr_wdata[CODE_W-1:0];
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mtrap_ctrl.sv
`timescale 1ns/1ps
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_tmr_i,
    input  logic              irq_ext_i,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              mret_i,
    input  logic              csr_req_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              ext_ack_o,
    output logic              priv_m_o
);
    trap_dec_t       dec;
    prv_e            prv;
    logic            gie, en_tmr, en_ext, tv_vec;
    logic [XLEN-3:0] tv_base, epc;

    mtrap_arb u_arb (
        .exc_req  (exc_req_i),
        .exc_code (exc_code_i),
        .mret     (mret_i),
        .line_tmr (irq_tmr_i),
        .line_ext (irq_ext_i),
        .en_tmr   (en_tmr),
        .en_ext   (en_ext),
        .gie      (gie),
        .prv      (prv),
        .dec      (dec),
        .ext_ack  (ext_ack_o)
    );

    mtrap_regs #(.XLEN(XLEN)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .trap_pc     (cur_pc_i),
        .line_tmr    (irq_tmr_i),
        .line_ext    (irq_ext_i),
        .csr_req     (csr_req_i),
        .csr_we      (csr_we_i),
        .csr_addr    (csr_addr_i),
        .csr_wdata   (csr_wdata_i),
        .csr_rdata   (csr_rdata_o),
        .csr_illegal (csr_illegal_o),
        .prv         (prv),
        .gie         (gie),
        .en_tmr      (en_tmr),
        .en_ext      (en_ext),
        .tv_base     (tv_base),
        .tv_vec      (tv_vec),
        .epc         (epc)
    );

    mtrap_vec #(.XLEN(XLEN)) u_vec (
        .dec      (dec),
        .tv_base  (tv_base),
        .tv_vec   (tv_vec),
        .epc      (epc),
        .redir    (redirect_o),
        .redir_pc (redirect_pc_o)
    );

    assign priv_m_o = (prv == PRV_M);
endmodule

// File: rtl/mtrap_chk.sv
`timescale 1ns/1ps
module mtrap_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_ext_i,
    input logic            exc_req_i,
    input logic            mret_i,
    input logic [XLEN-1:0] cur_pc_i,
    input logic            csr_req_i,
    input logic            csr_illegal_o,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            ext_ack_o,
    input logic            priv_m_o,
    input logic            gie,
    input logic [XLEN-3:0] tv_base,
    input logic [XLEN-3:0] epc
);
    AST_ACK_WITH_LINE: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |-> (irq_ext_i && redirect_o && !exc_req_i && !mret_i)); // R8

    AST_EXC_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        exc_req_i |-> (redirect_o && redirect_pc_o == {tv_base, 2'b00})); // R4

    AST_EXC_ENTERS_M: assert property (@(posedge clk) disable iff (rst)
        exc_req_i |=> (priv_m_o && !gie)); // R6

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        exc_req_i |=> (epc == $past(cur_pc_i[XLEN-1:2]))); // R6

    AST_USER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        csr_illegal_o |-> (csr_req_i && !priv_m_o)); // R9

    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        csr_illegal_o |-> (csr_rdata_o == '0)); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (priv_m_o && !gie && !exc_req_i && !mret_i) |-> !redirect_o); // R2

    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !exc_req_i) |-> (redirect_o && redirect_pc_o == {epc, 2'b00})); // R7
endmodule

bind mtrap_ctrl mtrap_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_ext_i     (irq_ext_i),
    .exc_req_i     (exc_req_i),
    .mret_i        (mret_i),
    .cur_pc_i      (cur_pc_i),
    .csr_req_i     (csr_req_i),
    .csr_illegal_o (csr_illegal_o),
    .csr_rdata_o   (csr_rdata_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .ext_ack_o     (ext_ack_o),
    .priv_m_o      (priv_m_o),
    .gie           (gie),
    .tv_base       (tv_base),
    .epc           (epc)
);

// File: tb/sim_mtrap_ctrl.sv
`timescale 1ns/1ps
module sim_mtrap_ctrl;
    localparam logic [11:0] S_ST = 12'h300, S_IE = 12'h304, S_TV = 12'h305;
    localparam logic [11:0] S_EP = 12'h341, S_CA = 12'h342, S_PD = 12'h344;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_tmr = 1'b0, irq_ext = 1'b0, exc_req = 1'b0, mret = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] cur_pc = '0;
    logic        csr_req = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redirect_pc;
    logic        csr_illegal, redirect, ext_ack, priv_m;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mtrap_ctrl u0 (
        .clk(clk), .rst(rst), .irq_tmr_i(irq_tmr), .irq_ext_i(irq_ext),
        .exc_req_i(exc_req), .exc_code_i(exc_code), .cur_pc_i(cur_pc), .mret_i(mret),
        .csr_req_i(csr_req), .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc), .ext_ack_o(ext_ack), .priv_m_o(priv_m)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk);
        #1;
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1;
        d = csr_rdata;
        csr_req = 1'b0;
    endtask

    task automatic pulse_mret();
        @(negedge clk);
        mret = 1'b1;
        @(posedge clk);
        #1;
        mret = 1'b0;
    endtask

    task automatic go_user();
        csr_wr(S_ST, 32'h0);
        csr_wr(S_EP, 32'h200);
        pulse_mret();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        // R1 reset state
        do_reset();
        chk("R1 priv", {31'b0, priv_m}, 32'h1);
        chk("R1 redirect", {31'b0, redirect}, 32'h0);
        csr_rd(S_ST, rd); chk("R1 status", rd, 32'h8);
        csr_rd(S_IE, rd); chk("R1 enables", rd, 32'h0);
        csr_rd(S_TV, rd); chk("R1 vector", rd, 32'h0);
        csr_rd(S_EP, rd); chk("R1 epc", rd, 32'h0);
        csr_rd(S_CA, rd); chk("R1 cause", rd, 32'h0);

        // R2 R3 R5 R6 R8 sweep
        for (int i = 0; i < 128; i++) begin
            logic pu, g, et, ee, lt, le, vm, en, tk_t, tk_e, old_g;
            logic [31:0] pc, base, exp_pc;
            pu = i[0]; g = i[1]; et = i[2]; ee = i[3]; lt = i[4]; le = i[5]; vm = i[6];
            pc = 32'h1000 + i * 4;
            base = 32'h4000;
            do_reset();
            csr_wr(S_TV, base | {31'b0, vm});
            csr_wr(S_IE, ({31'b0, et} << 7) | ({31'b0, ee} << 11));
            if (pu) go_user();
            else csr_wr(S_ST, 32'h1800 | ({31'b0, g} << 3));
            old_g = pu ? 1'b0 : g;
            en = pu || g;
            tk_t = lt && et && en;
            tk_e = !tk_t && le && ee && en;
            exp_pc = base + (vm ? (tk_t ? 32'd28 : 32'd44) : 32'd0);
            @(negedge clk);
            irq_tmr = lt; irq_ext = le; cur_pc = pc;
            #1;
            chk("R2 redirect", {31'b0, redirect}, {31'b0, tk_t || tk_e});
            if (tk_t || tk_e) chk("R5 target", redirect_pc, exp_pc);
            chk("R8 ack", {31'b0, ext_ack}, {31'b0, tk_e});
            @(posedge clk);
            #1;
            irq_tmr = 1'b0; irq_ext = 1'b0;
            if (tk_t || tk_e) begin
                chk("R6 priv", {31'b0, priv_m}, 32'h1);
                csr_rd(S_CA, rd);
                chk("R3 cause", rd, tk_t ? 32'h8000_0007 : 32'h8000_000B);
                csr_rd(S_EP, rd); chk("R6 epc", rd, pc);
                csr_rd(S_ST, rd);
                chk("R6 status", rd, (pu ? 32'h0 : 32'h1800) | (old_g ? 32'h80 : 32'h0));
            end else begin
                chk("R2 priv kept", {31'b0, priv_m}, {31'b0, !pu});
            end
        end

        // R4 exception beats return and both interrupts
        do_reset();
        csr_wr(S_TV, 32'h8001);
        csr_wr(S_IE, 32'h880);
        csr_wr(S_ST, 32'h1808);
        @(negedge clk);
        irq_tmr = 1'b1; irq_ext = 1'b1; exc_req = 1'b1; exc_code = 4'd2; mret = 1'b1; cur_pc = 32'h3000;
        #1;
        chk("R4 target base", redirect_pc, 32'h8000);
        chk("R8 no ack on exc", {31'b0, ext_ack}, 32'h0);
        @(posedge clk);
        #1;
        irq_tmr = 1'b0; irq_ext = 1'b0; exc_req = 1'b0; mret = 1'b0;
        csr_rd(S_CA, rd); chk("R4 cause", rd, 32'h2);
        csr_rd(S_ST, rd); chk("R6 status after exc", rd, 32'h1880);

        // R7 return to machine
        @(negedge clk);
        mret = 1'b1;
        #1;
        chk("R7 redirect", {31'b0, redirect}, 32'h1);
        chk("R7 target", redirect_pc, 32'h3000);
        @(posedge clk);
        #1;
        mret = 1'b0;
        chk("R7 priv M", {31'b0, priv_m}, 32'h1);
        csr_rd(S_ST, rd); chk("R7 status", rd, 32'h88);

        // R7 return to user, R9 user access
        csr_wr(S_EP, 32'h500);
        csr_wr(S_ST, 32'h0);
        pulse_mret();
        chk("R7 priv U", {31'b0, priv_m}, 32'h0);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = S_ST;
        #1;
        chk("R9 illegal", {31'b0, csr_illegal}, 32'h1);
        chk("R9 read zero", csr_rdata, 32'h0);
        csr_req = 1'b0;
        csr_wr(S_IE, 32'h0);
        @(negedge clk);
        exc_req = 1'b1; exc_code = 4'd8; cur_pc = 32'h600;
        #1;
        chk("R4 vectored exc to base", redirect_pc, 32'h8000);
        @(posedge clk);
        #1;
        exc_req = 1'b0;
        csr_rd(S_IE, rd); chk("R9 write dropped", rd, 32'h880);
        csr_rd(S_CA, rd); chk("R4 ecall cause", rd, 32'h8);
        csr_rd(S_ST, rd); chk("R6 status from U", rd, 32'h80);

        // R10 pending read-only and status write rules
        do_reset();
        csr_wr(S_PD, 32'hFFFF_FFFF);
        csr_rd(S_PD, rd); chk("R10 pending idle", rd, 32'h0);
        @(negedge clk); irq_tmr = 1'b1;
        csr_rd(S_PD, rd); chk("R10 pending tmr", rd, 32'h80);
        @(negedge clk); irq_ext = 1'b1;
        csr_rd(S_PD, rd); chk("R10 pending both", rd, 32'h880);
        @(negedge clk); irq_tmr = 1'b0; irq_ext = 1'b0;
        csr_wr(S_ST, 32'h1808);
        csr_rd(S_ST, rd); chk("R10 status M", rd, 32'h1808);
        csr_wr(S_ST, 32'h0888);
        csr_rd(S_ST, rd); chk("R10 mpp 01 kept", rd, 32'h1808);
        csr_wr(S_ST, 32'h1000);
        csr_rd(S_ST, rd); chk("R10 mpp 10 kept", rd, 32'h1800);
        csr_wr(S_ST, 32'h0);
        csr_rd(S_ST, rd); chk("R10 mpp 00", rd, 32'h0);

        // R5 mode bit 1 reads zero
        csr_wr(S_TV, 32'h1003);
        csr_rd(S_TV, rd); chk("R5 tvec 3", rd, 32'h1001);
        csr_wr(S_TV, 32'h2002);
        csr_rd(S_TV, rd); chk("R5 tvec 2", rd, 32'h2000);

        // R11 write colliding with a trap
        do_reset();
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = S_IE; csr_wdata = 32'h880;
        exc_req = 1'b1; exc_code = 4'd3; cur_pc = 32'h700;
        @(posedge clk);
        #1;
        csr_req = 1'b0; csr_we = 1'b0; exc_req = 1'b0;
        csr_rd(S_IE, rd); chk("R11 write dropped", rd, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule